// File: doc/BRIEF.md
# Pipelined Fixed-Point PID Speed Regulator

This block closes a discrete-time PID loop around a DC motor. A sample strobe carries a signed speed setpoint and a signed measured speed. The block forms the error and runs it through proportional, integral and derivative paths. It adds the three terms and saturates the sum to a 10-bit unsigned duty command for a downstream PWM stage. A one-clock valid pulse marks each new duty value.

The three gains are signed Q8.8 values. A host loads them with a single-cycle write strobe, a two-bit selector and a data word. The writes land in shadow registers. The computation copies those registers on each accepted sample, so one sample never mixes old and new gains.

The integrator is wider than the error and is clamped to parameter bounds, so it cannot wind up. The derivative path keeps the previous sample's error in a register.

Registers split the arithmetic into stages, so the latency is fixed. While a sample is in flight the block ignores new strobes.

Top module: `pid_speed_ctrl`

## Requirements
- R1: The error is setpoint minus speed, formed one bit wider than the inputs so that it never wraps.
- R2: A write with `gain_we` high stores `gain_wdata` as a signed Q8.8 gain. The selector `gain_sel` picks the gain: 0 = proportional, 1 = integral, 2 = derivative. Selector 3 changes nothing.
- R3: An accepted sample captures all three shadow gains on its strobe edge. A write that arrives while a sample is in flight affects only later samples.
- R4: On each accepted sample the integrator adds the error and then clamps the sum to [I_MIN, I_MAX]. With the default parameters these bounds are -20000 and +20000. The stored value never leaves that range.
- R5: The derivative input is the current error minus the previous accepted sample's error. The previous error updates once per accepted sample.
- R6: Each term is its gain times its input, shifted right by 8 with rounding toward minus infinity. The terms are: proportional gain times the error; integral gain times the updated integrator; derivative gain times the error difference. The sum of the three terms appears on `duty`, saturated to 0..1023.
- R7: The strobe edge that accepts a sample is followed by three more rising edges. On the third of them, `duty_vld` goes high for exactly one clock. `duty` changes only together with `duty_vld`.
- R8: A strobe seen on any of the three edges after an accepted one is dropped. It produces no output, and it leaves the integrator, the previous error and the captured gains unchanged.
- R9: Synchronous reset clears the integrator, the previous error, `duty`, `duty_vld` and all gains to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | Sample strobe |
| setpoint | input | 16 | Signed commanded speed |
| speed | input | 16 | Signed measured speed |
| gain_we | input | 1 | Gain write strobe |
| gain_sel | input | 2 | Gain selector (0 P, 1 I, 2 D, 3 none) |
| gain_wdata | input | 16 | Signed Q8.8 gain value |
| duty | output | 10 | Saturated duty command |
| duty_vld | output | 1 | One-clock pulse marking a new duty value |

## Verification
The hardest state to reach from the ports is a clamped integrator whose later unwinding shows at the output. A small integral gain keeps the integral term below saturation. Two large positive errors then drive the integrator onto its upper clamp, and a negative error follows. The duty value after that negative error differs from the unclamped result, and the same is done with a negative gain against the lower clamp. Dropped strobes are provoked by holding the strobe high through the busy window with different inputs. The next real sample then shows whether the integrator or the previous error was disturbed.

// File: rtl/pid_pkg.sv
package pid_pkg;

  // Gain selector codes; the bank decodes these positions directly.
  typedef enum logic [1:0] {
    SEL_KP   = 2'd0,
    SEL_KI   = 2'd1,
    SEL_KD   = 2'd2,
    SEL_NONE = 2'd3
  } gain_sel_e;

  localparam int NUM_GAINS = 3;

endpackage

// File: rtl/pid_gain_bank.sv
module pid_gain_bank
  import pid_pkg::*;
#(
  parameter int GW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_sel,
  input  logic signed [GW-1:0] wr_data,
  input  logic                 load,
  output logic signed [GW-1:0] kp_o,
  output logic signed [GW-1:0] ki_o,
  output logic signed [GW-1:0] kd_o
);

  logic signed [GW-1:0] shadow [NUM_GAINS];
  logic signed [GW-1:0] active [NUM_GAINS];
  logic                 wr_dead;

  // Event: a write aimed at the unused selector code.
  assign wr_dead = wr_en && (wr_sel == SEL_NONE);

  for (genvar g = 0; g < NUM_GAINS; g++) begin : g_gain
    logic hit;
    assign hit = wr_en && (wr_sel == 2'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[g] <= '0;
        active[g] <= '0;
      end else begin
        if (hit)  shadow[g] <= wr_data;
        if (load) active[g] <= shadow[g];
      end
    end
  end

  assign kp_o = active[int'(SEL_KP)];
  assign ki_o = active[int'(SEL_KI)];
  assign kd_o = active[int'(SEL_KD)];

  // Captured gains move only on an accepted sample (R3).
  assert_gains_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(kp_o) && $stable(ki_o) && $stable(kd_o)));

  // Selector 3 leaves every shadow gain untouched (R2).
  assert_dead_write_R2: assert property (@(posedge clk) disable iff (rst)
    wr_dead |=> ($stable(shadow[0]) && $stable(shadow[1]) && $stable(shadow[2])));

endmodule

// File: rtl/pid_integ_diff.sv
module pid_integ_diff #(
  parameter int     EW    = 17,
  parameter int     ACC_W = 32,
  parameter longint I_MAX = 20000,
  parameter longint I_MIN = -20000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic signed [EW-1:0]    err_in,
  output logic                    out_v,
  output logic signed [EW-1:0]    err_o,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [EW:0]      diff_o
);

  localparam int AW1 = ACC_W + 1;
  localparam int DFW = EW + 1;
  localparam logic signed [AW1-1:0] HI_S = AW1'(I_MAX);
  localparam logic signed [AW1-1:0] LO_S = AW1'(I_MIN);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [EW-1:0]    prev_q;
  logic signed [AW1-1:0]   acc_sum;
  logic                    hit_hi;
  logic                    hit_lo;

  function automatic logic signed [ACC_W-1:0] clamp_acc(input logic signed [AW1-1:0] v);
    if (v > HI_S)      return ACC_W'(I_MAX);
    else if (v < LO_S) return ACC_W'(I_MIN);
    else               return v[ACC_W-1:0];
  endfunction

  assign acc_sum = AW1'(acc_q) + AW1'(err_in);
  assign hit_hi  = in_v && (acc_sum > HI_S);
  assign hit_lo  = in_v && (acc_sum < LO_S);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      prev_q <= '0;
      out_v  <= 1'b0;
      err_o  <= '0;
      diff_o <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        acc_q  <= clamp_acc(acc_sum);
        prev_q <= err_in;
        err_o  <= err_in;
        diff_o <= DFW'(err_in) - DFW'(prev_q);
      end
    end
  end

  assign acc_o = acc_q;

  assert_acc_bounded_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_q <= ACC_W'(I_MAX)) && (acc_q >= ACC_W'(I_MIN)));

  assert_clip_high_R4: assert property (@(posedge clk) disable iff (rst)
    hit_hi |=> (acc_q == ACC_W'(I_MAX)));

  assert_clip_low_R4: assert property (@(posedge clk) disable iff (rst)
    hit_lo |=> (acc_q == ACC_W'(I_MIN)));

  assert_prev_tracks_R5: assert property (@(posedge clk) disable iff (rst)
    in_v |=> (prev_q == $past(err_in)));

  assert_state_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_v |=> ($stable(acc_q) && $stable(prev_q)));

endmodule

// File: rtl/pid_mul_stage.sv
module pid_mul_stage #(
  parameter int EW    = 17,
  parameter int ACC_W = 32,
  parameter int GW    = 16,
  parameter int FRAC  = 8,
  parameter int PW    = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_v,
  input  logic signed [EW-1:0]    err_in,
  input  logic signed [ACC_W-1:0] acc_in,
  input  logic signed [EW:0]      diff_in,
  input  logic signed [GW-1:0]    kp,
  input  logic signed [GW-1:0]    ki,
  input  logic signed [GW-1:0]    kd,
  output logic                    out_v,
  output logic signed [PW-1:0]    p_t,
  output logic signed [PW-1:0]    i_t,
  output logic signed [PW-1:0]    d_t
);

  // Fixed-point product, scaled back by FRAC with floor rounding.
  function automatic logic signed [PW-1:0] mul_q(input logic signed [PW-1:0] a,
                                                 input logic signed [PW-1:0] b);
    logic signed [PW-1:0] prod;
    prod = a * b;
    return prod >>> FRAC;
  endfunction

  logic signed [PW-1:0] p_d, i_d, d_d;

  assign p_d = mul_q(PW'(kp), PW'(err_in));
  assign i_d = mul_q(PW'(ki), PW'(acc_in));
  assign d_d = mul_q(PW'(kd), PW'(diff_in));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v <= 1'b0;
      p_t   <= '0;
      i_t   <= '0;
      d_t   <= '0;
    end else begin
      out_v <= in_v;
      if (in_v) begin
        p_t <= p_d;
        i_t <= i_d;
        d_t <= d_d;
      end
    end
  end

  assert_terms_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_v |=> ($stable(p_t) && $stable(i_t) && $stable(d_t)));

endmodule

// File: rtl/pid_out_sat.sv
module pid_out_sat #(
  parameter int PW    = 48,
  parameter int OUT_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  logic signed [PW-1:0] p_t,
  input  logic signed [PW-1:0] i_t,
  input  logic signed [PW-1:0] d_t,
  output logic [OUT_W-1:0]     duty,
  output logic                 duty_vld
);

  localparam int SW = PW + 2;
  localparam int OUT_MAX = (1 << OUT_W) - 1;
  localparam logic signed [SW-1:0] MAX_S = SW'(OUT_MAX);

  logic signed [SW-1:0] sum;
  logic                 clip_hi;
  logic                 clip_lo;

  function automatic logic [OUT_W-1:0] sat_duty(input logic signed [SW-1:0] s);
    if (s < 0)          return '0;
    else if (s > MAX_S) return '1;
    else                return s[OUT_W-1:0];
  endfunction

  assign sum     = SW'(p_t) + SW'(i_t) + SW'(d_t);
  assign clip_hi = in_v && (sum > MAX_S);
  assign clip_lo = in_v && (sum < 0);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty     <= '0;
      duty_vld <= 1'b0;
    end else begin
      duty_vld <= in_v;
      if (in_v) duty <= sat_duty(sum);
    end
  end

  assert_sat_top_R6: assert property (@(posedge clk) disable iff (rst)
    clip_hi |=> (duty == OUT_W'(OUT_MAX)));

  assert_sat_floor_R6: assert property (@(posedge clk) disable iff (rst)
    clip_lo |=> (duty == '0));

  assert_duty_moves_with_vld_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty) |-> duty_vld);

  assert_vld_single_R7: assert property (@(posedge clk) disable iff (rst)
    duty_vld |=> !duty_vld);

endmodule

// File: rtl/pid_speed_ctrl.sv
module pid_speed_ctrl #(
  parameter int     DW    = 16,
  parameter int     GW    = 16,
  parameter int     FRAC  = 8,
  parameter int     ACC_W = 32,
  parameter int     OUT_W = 10,
  parameter longint I_MAX = 20000,
  parameter longint I_MIN = -20000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] setpoint,
  input  logic signed [DW-1:0] speed,
  input  logic                 gain_we,
  input  logic [1:0]           gain_sel,
  input  logic signed [GW-1:0] gain_wdata,
  output logic [OUT_W-1:0]     duty,
  output logic                 duty_vld
);

  localparam int EW  = DW + 1;
  localparam int MW  = (ACC_W > EW + 1) ? ACC_W : EW + 1;
  localparam int PW  = MW + GW;

  logic                    s1_v, s2_v, s3_v;
  logic                    busy;
  logic                    stb_take;
  logic signed [EW-1:0]    err_q;
  logic signed [EW-1:0]    s2_err;
  logic signed [ACC_W-1:0] s2_acc;
  logic signed [EW:0]      s2_diff;
  logic signed [GW-1:0]    kp, ki, kd;
  logic signed [PW-1:0]    p_t, i_t, d_t;

  assign busy     = s1_v | s2_v | s3_v;
  assign stb_take = smp_stb && !busy && !rst;

  // Stage 1: error formation, one bit wider than the inputs (R1).
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      err_q <= '0;
    end else begin
      s1_v <= stb_take;
      if (stb_take) err_q <= EW'(setpoint) - EW'(speed);
    end
  end

  pid_gain_bank #(.GW(GW)) u_gains (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (gain_we),
    .wr_sel  (gain_sel),
    .wr_data (gain_wdata),
    .load    (stb_take),
    .kp_o    (kp),
    .ki_o    (ki),
    .kd_o    (kd)
  );

  pid_integ_diff #(
    .EW(EW), .ACC_W(ACC_W), .I_MAX(I_MAX), .I_MIN(I_MIN)
  ) u_integ (
    .clk    (clk),
    .rst    (rst),
    .in_v   (s1_v),
    .err_in (err_q),
    .out_v  (s2_v),
    .err_o  (s2_err),
    .acc_o  (s2_acc),
    .diff_o (s2_diff)
  );

  pid_mul_stage #(
    .EW(EW), .ACC_W(ACC_W), .GW(GW), .FRAC(FRAC), .PW(PW)
  ) u_mul (
    .clk     (clk),
    .rst     (rst),
    .in_v    (s2_v),
    .err_in  (s2_err),
    .acc_in  (s2_acc),
    .diff_in (s2_diff),
    .kp      (kp),
    .ki      (ki),
    .kd      (kd),
    .out_v   (s3_v),
    .p_t     (p_t),
    .i_t     (i_t),
    .d_t     (d_t)
  );

  pid_out_sat #(.PW(PW), .OUT_W(OUT_W)) u_sat (
    .clk      (clk),
    .rst      (rst),
    .in_v     (s3_v),
    .p_t      (p_t),
    .i_t      (i_t),
    .d_t      (d_t),
    .duty     (duty),
    .duty_vld (duty_vld)
  );

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (rst)
    duty_vld == $past(stb_take, 4));

  assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (rst)
    stb_take |=> !stb_take);

  assert_err_formed_R1: assert property (@(posedge clk) disable iff (rst)
    stb_take |=> (err_q == $past(EW'(setpoint) - EW'(speed))));

endmodule

// File: tb/pid_speed_ctrl_tb.sv
module pid_speed_ctrl_tb;

  logic               clk = 1'b0;
  logic               rst;
  logic               smp_stb;
  logic signed [15:0] setpoint;
  logic signed [15:0] speed;
  logic               gain_we;
  logic [1:0]         gain_sel;
  logic signed [15:0] gain_wdata;
  logic [9:0]         duty;
  logic               duty_vld;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  // Bench-side view of the requirements.
  longint sh_g [3];
  longint m_acc, m_prev;
  longint last_duty;

  always #5 clk = ~clk;

  pid_speed_ctrl u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .setpoint(setpoint), .speed(speed),
    .gain_we(gain_we), .gain_sel(gain_sel), .gain_wdata(gain_wdata),
    .duty(duty), .duty_vld(duty_vld)
  );

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Floor division by 256, done with exact integer division.
  function automatic longint floor_q8(longint x);
    longint r;
    r = ((x % 256) + 256) % 256;
    return (x - r) / 256;
  endfunction

  function automatic longint model_step(longint sp, longint spd);
    longint e, s;
    e = sp - spd;
    m_acc = m_acc + e;
    if (m_acc > 20000)  m_acc = 20000;
    if (m_acc < -20000) m_acc = -20000;
    s = floor_q8(sh_g[0] * e) + floor_q8(sh_g[1] * m_acc) + floor_q8(sh_g[2] * (e - m_prev));
    m_prev = e;
    if (s < 0)    s = 0;
    if (s > 1023) s = 1023;
    return s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_stb = 1'b0; gain_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_acc = 0; m_prev = 0; last_duty = 0;
    for (int k = 0; k < 3; k++) sh_g[k] = 0;
  endtask

  task automatic wr_gain(int sel, longint val);
    @(negedge clk);
    gain_we = 1'b1; gain_sel = 2'(sel); gain_wdata = 16'(val);
    @(negedge clk);
    gain_we = 1'b0;
    if (sel < 3) sh_g[sel] = longint'($signed(16'(val)));
  endtask

  // One sample; hold keeps the strobe high for extra edges inside the busy window.
  task automatic do_sample(longint sp, longint spd, int hold, string req);
    longint exp;
    exp = model_step(sp, spd);
    @(negedge clk);
    smp_stb = 1'b1; setpoint = 16'(sp); speed = 16'(spd);
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      if (n <= hold) begin
        smp_stb = 1'b1; setpoint = 16'(sp + 777 * n); speed = 16'(spd - 300);
      end else smp_stb = 1'b0;
      if (n == 4) begin
        check(req, "duty_vld at latency", longint'(duty_vld), 1);
        check(req, "duty value", longint'(duty), exp);
      end else begin
        check(req, "duty_vld outside slot", longint'(duty_vld), 0);
        if (n < 4) check("R7", "duty held", longint'(duty), last_duty);
      end
    end
    last_duty = exp;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R9", "duty after reset", longint'(duty), 0);
    check("R9", "duty_vld after reset", longint'(duty_vld), 0);
  endtask

  task automatic t_proportional();
    wr_gain(0, 16'sh0100);
    do_sample(500, 200, 0, "R1");
    do_sample(-100, 50, 0, "R6");
    do_sample(1200, -300, 0, "R6");
  endtask

  task automatic t_full_mix();
    wr_gain(0, 16'sh0080);
    wr_gain(1, 16'sh0010);
    wr_gain(2, 16'sh0200);
    do_sample(900, 400, 0, "R5");
    do_sample(700, 400, 0, "R5");
    do_sample(-50, 10, 0, "R6");
    do_sample(2000, 1990, 0, "R4");
  endtask

  task automatic t_clamp();
    do_reset();
    wr_gain(1, 16'sh0008);
    do_sample(12000, 0, 0, "R4");
    do_sample(12000, 0, 0, "R4");
    do_sample(0, 5000, 0, "R4");
    do_reset();
    wr_gain(1, -8);
    do_sample(-15000, 0, 0, "R4");
    do_sample(0, 15000, 0, "R4");
    do_sample(4000, 0, 0, "R4");
  endtask

  task automatic t_gain_timing();
    do_reset();
    wr_gain(0, 16'sh0100);
    begin
      longint exp;
      exp = model_step(300, 0);
      @(negedge clk);
      smp_stb = 1'b1; setpoint = 16'sd300; speed = 16'sd0;
      @(negedge clk);
      smp_stb = 1'b0;
      gain_we = 1'b1; gain_sel = 2'd0; gain_wdata = 16'sh0200;
      @(negedge clk);
      gain_we = 1'b0;
      sh_g[0] = 512;
      @(negedge clk);
      @(negedge clk);
      check("R3", "duty_vld with mid write", longint'(duty_vld), 1);
      check("R3", "old gain in flight", longint'(duty), exp);
      last_duty = exp;
    end
    do_sample(300, 0, 0, "R3");
  endtask

  task automatic t_dead_select();
    wr_gain(3, 16'sh7F00);
    do_sample(100, 0, 0, "R2");
    wr_gain(2, 16'sh0100);
    wr_gain(3, 16'sh8000);
    do_sample(250, 0, 0, "R2");
  endtask

  task automatic t_busy_drop();
    do_reset();
    wr_gain(0, 16'sh0100);
    wr_gain(1, 16'sh0020);
    wr_gain(2, 16'sh0100);
    do_sample(200, 0, 3, "R8");
    repeat (3) begin
      @(negedge clk);
      check("R8", "no output from dropped strobe", longint'(duty_vld), 0);
    end
    do_sample(150, 0, 0, "R8");
  endtask

  task automatic t_reset_midrun();
    do_sample(800, 0, 0, "R9");
    do_reset();
    check("R9", "duty cleared", longint'(duty), 0);
    wr_gain(1, 16'sh0100);
    wr_gain(2, 16'sh0100);
    do_sample(40, 0, 0, "R9");
  endtask

  initial begin
    rst = 1'b1; smp_stb = 1'b0; setpoint = '0; speed = '0;
    gain_we = 1'b0; gain_sel = '0; gain_wdata = '0;
    t_reset_state();
    t_proportional();
    t_full_mix();
    t_clamp();
    t_gain_timing();
    t_dead_select();
    t_busy_drop();
    t_reset_midrun();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule